// File: doc/BRIEF.md
# Instruction Address Sequencer

This block keeps the address of the next instruction that a processor core will execute. It is a single register of `ADDR_W` bits, 16 by default. On each rising clock edge where the load enable is high, the register takes a new value. A two-bit source code picks that value from three options: the current address plus one, an address computed by an external address adder, or a value taken from the shared data bus.

The core's control logic drives the load enable and the source code. The address adder and the bus are outside this block, and only their results arrive here. The stored address is always visible on the output. The output comes straight from the register, so nothing on the inputs can reach it between clock edges. A synchronous reset clears the address to zero. Source code 3 is reserved. The sequencer ignores it as a load request, and a simulation check reports any cycle that issues it with load enabled.

Top module: `pc_seq_unit`

## Requirements
- R1: On a rising edge with `rst` high, `pc_q` becomes 0. This holds whatever the values of `ld_en`, `nxt_sel` and the data inputs.
- R2: On a rising edge with `rst` low, `ld_en` high and `nxt_sel` = 2'b00, `pc_q` becomes its previous value plus one.
- R3: On a rising edge with `rst` low, `ld_en` high and `nxt_sel` = 2'b01, `pc_q` becomes the value of `adder_addr`.
- R4: On a rising edge with `rst` low, `ld_en` high and `nxt_sel` = 2'b10, `pc_q` becomes the value of `bus_addr`.
- R5: Incrementing from the all-ones address (0xFFFF at the default width) gives 0. There is no carry output.
- R6: On a rising edge with `rst` low and `ld_en` low, `pc_q` keeps its value for every `nxt_sel`, `adder_addr` and `bus_addr`.
- R7: `nxt_sel` = 2'b11 is reserved. When it is presented, the register does not load, and a simulation assertion reports any cycle with `ld_en` high and `nxt_sel` = 2'b11. Callers must never issue that combination.
- R8: `pc_q` changes only at a rising clock edge. Changing any input between edges leaves `pc_q` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the address |
| ld_en | input | 1 | Load enable; while low the address holds |
| nxt_sel | input | 2 | Next-address source: 00 increment, 01 adder, 10 bus, 11 reserved |
| adder_addr | input | ADDR_W | Result from the external address adder |
| bus_addr | input | ADDR_W | Value on the shared data bus |
| pc_q | output | ADDR_W | Current instruction address, registered |

## Verification
Properties are checked on every cycle for:
- the reset clear,
- the three load sources, each compared with its own input or with the previous address plus one,
- the hold while load is low,
- the absence of any load with the reserved code.

Some behaviours can only be shown by the bench's scenarios. One is the wrap from all-ones to zero, which the bench sets up by loading 0xFFFF from the bus and then incrementing. Another is the reset winning over a load issued in the same cycle. A third is the output staying put while the inputs move between edges, which the bench checks by sampling `pc_q` before the edge that would take in the new inputs.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // Next-address source codes; the numeric value is the select encoding.
  typedef enum logic [1:0] {
    SRC_INC   = 2'b00,
    SRC_ADDER = 2'b01,
    SRC_BUS   = 2'b10,
    SRC_RSVD  = 2'b11
  } pc_src_e;

  // Number of real (non-reserved) sources.
  localparam int unsigned SRC_COUNT = 3;

  // Default address width.
  localparam int unsigned PC_W_DEFAULT = 16;

endpackage

// File: rtl/pc_src_decode.sv
module pc_src_decode
  import pc_pkg::*;
#(
  parameter int unsigned NSRC = SRC_COUNT
) (
  input  pc_src_e         sel,
  output logic [NSRC-1:0] src_hit,
  output logic            src_rsvd
);

  // One hit line per real source; the code value equals the source index.
  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign src_hit[i] = (sel == pc_src_e'(i));
  end

  assign src_rsvd = (sel == SRC_RSVD);

endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
  import pc_pkg::*;
#(
  parameter int unsigned ADDR_W = PC_W_DEFAULT,
  parameter int unsigned NSRC   = SRC_COUNT
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] adder_addr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   src_hit,
  output logic [ADDR_W-1:0] nxt_addr
);

  // Sequential step: modulo 2^ADDR_W, carry discarded.
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [NSRC-1:0][ADDR_W-1:0] cand;
  logic [NSRC-1:0][ADDR_W-1:0] masked;

  assign cand[SRC_INC]   = addr_step(cur_addr);
  assign cand[SRC_ADDER] = adder_addr;
  assign cand[SRC_BUS]   = bus_addr;

  // AND-OR selection driven by the one-hot hit vector.
  for (genvar i = 0; i < NSRC; i++) begin : g_mask
    assign masked[i] = cand[i] & {ADDR_W{src_hit[i]}};
  end

  always_comb begin
    nxt_addr = '0;
    for (int i = 0; i < NSRC; i++) begin
      nxt_addr = nxt_addr | masked[i];
    end
  end

endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  // Synchronous clear takes priority over the update strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (upd) begin
      q <= d;
    end
  end

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
  import pc_pkg::*;
#(
  parameter int unsigned ADDR_W = PC_W_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [1:0]        nxt_sel,
  input  logic [ADDR_W-1:0] adder_addr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] pc_q
);

  localparam int unsigned NSRC = SRC_COUNT;

  logic [NSRC-1:0]   src_hit;
  logic              src_rsvd;
  logic [ADDR_W-1:0] nxt_addr;
  logic              pc_upd;
  logic              rsvd_load_evt;

  pc_src_decode #(.NSRC(NSRC)) u_decode (
    .sel      (pc_src_e'(nxt_sel)),
    .src_hit  (src_hit),
    .src_rsvd (src_rsvd)
  );

  pc_next_mux #(.ADDR_W(ADDR_W), .NSRC(NSRC)) u_mux (
    .cur_addr   (pc_q),
    .adder_addr (adder_addr),
    .bus_addr   (bus_addr),
    .src_hit    (src_hit),
    .nxt_addr   (nxt_addr)
  );

  // A reserved code produces no hit, so it never loads.
  assign pc_upd        = ld_en & (|src_hit);
  assign rsvd_load_evt = ld_en & src_rsvd;

  pc_state_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .upd (pc_upd),
    .d   (nxt_addr),
    .q   (pc_q)
  );

  // Assertion support: reset seen at the previous edge.
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d == 1'b1) begin
      AST_RESET_CLEARS: assert (pc_q == '0) else $error("address not cleared after reset"); // R1
    end
  end

  AST_INCR_STEP: assert property (@(posedge clk) disable iff (rst)
    (ld_en && nxt_sel == 2'b00) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1))); // R2

  AST_ADDER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ld_en && nxt_sel == 2'b01) |=> (pc_q == $past(adder_addr))); // R3

  AST_BUS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ld_en && nxt_sel == 2'b10) |=> (pc_q == $past(bus_addr))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!ld_en || nxt_sel == 2'b11) |=> $stable(pc_q)); // R6

  AST_NO_RESERVED_LOAD: assert property (@(posedge clk) disable iff (rst)
    !rsvd_load_evt); // R7

endmodule

// File: tb/pc_seq_unit_tb.sv
`timescale 1ns/100ps
module pc_seq_unit_tb;

  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         ld_en;
  logic [1:0]   nxt_sel;
  logic [W-1:0] adder_addr;
  logic [W-1:0] bus_addr;
  logic [W-1:0] pc_q;

  always #2.5 clk = ~clk;

  pc_seq_unit #(.ADDR_W(W)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .ld_en      (ld_en),
    .nxt_sel    (nxt_sel),
    .adder_addr (adder_addr),
    .bus_addr   (bus_addr),
    .pc_q       (pc_q)
  );

  typedef struct {
    logic [W-1:0] exp;
    string        req;
  } sb_item_t;

  sb_item_t     sb_q[$];
  int           n_cmp = 0;
  int           n_bad = 0;
  logic [W-1:0] model = '0;
  bit           done  = 1'b0;

  task automatic compare(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pc_q=%h expected %h", req, act, exp);
    end
  endtask

  // Driver: drives one cycle at the falling edge and queues the expected address.
  task automatic step(input logic r, input logic ld, input logic [1:0] s,
                      input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    sb_item_t it;
    @(negedge clk);
    rst = r; ld_en = ld; nxt_sel = s; adder_addr = a; bus_addr = b;
    if (r) model = '0;
    else if (ld) begin
      case (s)
        2'b00: model = model + 16'd1;
        2'b01: model = a;
        2'b10: model = b;
        default: model = model;
      endcase
    end
    it.exp = model;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor: one time unit after each rising edge, compares the oldest queued item.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      compare(pc_q, it.exp, it.req);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst = 1'b1; ld_en = 1'b0; nxt_sel = 2'b00; adder_addr = '0; bus_addr = '0;
    // R1: reset state
    step(1, 0, 2'b00, 16'h0000, 16'h0000, "R1");
    step(1, 0, 2'b00, 16'h1111, 16'h2222, "R1");
    // R2: increments
    step(0, 1, 2'b00, 16'h5555, 16'hAAAA, "R2");
    step(0, 1, 2'b00, 16'h5555, 16'hAAAA, "R2");
    step(0, 1, 2'b00, 16'h0000, 16'h0000, "R2");
    // R3: adder loads
    step(0, 1, 2'b01, 16'h1234, 16'hFFFF, "R3");
    step(0, 1, 2'b01, 16'hBEEF, 16'h0000, "R3");
    step(0, 1, 2'b00, 16'h0000, 16'h0000, "R2");
    // R4: bus loads
    step(0, 1, 2'b10, 16'h0F0F, 16'hC0DE, "R4");
    step(0, 1, 2'b10, 16'h0000, 16'h8001, "R4");
    // R6: hold while load is low, every selector
    step(0, 0, 2'b00, 16'h7777, 16'h6666, "R6");
    step(0, 0, 2'b01, 16'h7777, 16'h6666, "R6");
    step(0, 0, 2'b10, 16'h7777, 16'h6666, "R6");
    // R7: reserved code presented (load low, as callers must) does not load
    step(0, 0, 2'b11, 16'h3333, 16'h4444, "R7");
    // R5: wrap from all-ones to zero
    step(0, 1, 2'b10, 16'h0000, 16'hFFFF, "R4");
    step(0, 1, 2'b00, 16'h0000, 16'h0000, "R5");
    step(0, 1, 2'b00, 16'h0000, 16'h0000, "R5");
    // R1: reset wins over a load in the same cycle
    step(0, 1, 2'b01, 16'h9999, 16'h0000, "R3");
    step(1, 1, 2'b10, 16'h0000, 16'hABCD, "R1");
    step(0, 1, 2'b01, 16'h4321, 16'h0000, "R3");
    // R8: move inputs between edges; output must not follow before the edge
    @(negedge clk);
    rst = 1'b0; ld_en = 1'b1; nxt_sel = 2'b10; bus_addr = 16'hDEAD;
    #1 compare(pc_q, 16'h4321, "R8");
    nxt_sel = 2'b01; adder_addr = 16'h00FF;
    #0.5 compare(pc_q, 16'h4321, "R8");
    @(posedge clk); #1 compare(pc_q, 16'h00FF, "R8");
    model = 16'h00FF;
    step(0, 0, 2'b00, 16'h0000, 16'h0000, "R6");
    step(0, 0, 2'b00, 16'h0000, 16'h0000, "R6");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule